// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two entries from a page table held in memory. The page size is 8 KB. The top eight address bits select an entry in a 256-entry directory. That directory entry gives the base of a second-level table. The next eleven bits select one of 2048 entries in that table. The selected table entry gives the page frame. The low thirteen bits are the offset within the page and are never translated. A middle directory level is folded away, so it costs no memory access.

A translation unit starts a walk with a request/response handshake. The walker has a memory read port that allows only one read in flight. It also reads a directory base input, which it samples when it accepts a request. If either entry has its present bit clear, the walk ends early with a fault.

The walker is a four-state machine:

- **IDLE**: ready for a request. Accepting one moves it to READ_DIR.
- **READ_DIR**: issues the directory read and waits for memory ready. A present entry moves it to READ_PTE. An absent entry moves it to DONE with a fault.
- **READ_PTE**: issues the table read and waits for memory ready. It then moves to DONE and records either the result or a fault.
- **DONE**: presents the response for one cycle, then returns to IDLE.

Top module: `pgwalk`

## Requirements
- R1: After reset, req_ready is 1, and resp_valid and mem_rd_valid are 0.
- R2: The first read of a walk is at the directory base sampled on acceptance plus 4 × vaddr[31:24]. A later change of dir_base does not affect a walk already in progress.
- R3: The second read is at address {directory entry bits 31:13, vaddr[23:13], 2'b00}.
- R4: For a walk where both entries are present, the response carries resp_fault = 0 and resp_paddr = {table entry bits 31:13, vaddr[12:0]}.
- R5: A directory entry with bit 0 clear ends the walk with resp_fault = 1 and resp_paddr = 0, with no second read.
- R6: A table entry with bit 0 clear ends the walk with resp_fault = 1 and resp_paddr = 0.
- R7: While mem_rd_valid is high and mem_rd_ready is low, the read request and its address hold unchanged.
- R8: req_ready is high only in IDLE. A request held high during a walk or during its response starts no extra walk.
- R9: resp_valid is a single-cycle pulse, exactly one per walk, and req_ready is high in the following cycle.
- R10: For vaddr 0xD004000C, the directory index is 0xD0 (directory read at base + 0x340), the table index is 0x020, and the offset 0x00C passes through to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request (IDLE) |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Byte address of the directory |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_ready | input | 1 | Memory returns data this cycle |
| mem_rd_data | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Walk result valid (one cycle) |
| resp_paddr | output | 32 | Translated physical address |
| resp_fault | output | 1 | Entry not present at some level |

## Verification
Two of the walker's functions can fall in the same cycle. The first is presenting a result in DONE. The second is a requester that keeps req_valid high because it wants another translation. To provoke this, the bench holds req_valid high for entire walks, including the response cycle. It judges the outcome at the ports: req_ready must stay low, the number of memory reads must match a single walk, and exactly one response pulse must appear before IDLE returns. A similar collision is memory ready arriving with an absent directory entry. That must produce a fault in the very next cycle with no table read. The bench checks this both with directed addresses and with random addresses whose entries come from a hashed memory model.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_DIR = 2'd1,
        ST_READ_PTE = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_t;

    // log2 of the byte size of one table entry
    localparam int ENTRY_SHIFT = 2;

endpackage

// File: rtl/pgwalk_addr.sv
// Address generation for both walk levels and composition of the result.
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int DIR_W = 8,
    parameter int PT_W  = 11,
    parameter int OFF_W = 13,
    localparam int VA_W    = DIR_W + PT_W + OFF_W,
    localparam int FRAME_W = VA_W - OFF_W
) (
    input  logic [VA_W-1:0]    vaddr,
    input  logic [VA_W-1:0]    base,
    input  logic [FRAME_W-1:0] tframe,
    input  logic               second_level,
    input  logic [VA_W-1:0]    pte,
    output logic [VA_W-1:0]    rd_addr,
    output logic [VA_W-1:0]    paddr_ok
);

    localparam int PAD_W = OFF_W - PT_W - ENTRY_SHIFT;

    logic [DIR_W-1:0] dir_idx;
    logic [PT_W-1:0]  pt_idx;
    logic [VA_W-1:0]  dir_off;
    logic [VA_W-1:0]  pte_addr;

    assign dir_idx = vaddr[VA_W-1 -: DIR_W];
    assign pt_idx  = vaddr[OFF_W +: PT_W];
    assign dir_off = {{(VA_W-DIR_W-ENTRY_SHIFT){1'b0}}, dir_idx, {ENTRY_SHIFT{1'b0}}};

    generate
        if (PAD_W > 0) begin : g_pad
            assign pte_addr = {tframe, {PAD_W{1'b0}}, pt_idx, {ENTRY_SHIFT{1'b0}}};
        end else begin : g_nopad
            assign pte_addr = {tframe, pt_idx, {ENTRY_SHIFT{1'b0}}};
        end
    endgenerate

    assign rd_addr  = second_level ? pte_addr : (base + dir_off);
    assign paddr_ok = {pte[VA_W-1:OFF_W], vaddr[OFF_W-1:0]};

endmodule

// File: rtl/pgwalk_fsm.sv
// Walk sequencer: state register, captured request and result registers.
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter int DIR_W = 8,
    parameter int PT_W  = 11,
    parameter int OFF_W = 13,
    localparam int VA_W    = DIR_W + PT_W + OFF_W,
    localparam int FRAME_W = VA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [VA_W-1:0]    dir_base,
    input  logic               mem_rd_ready,
    input  logic [VA_W-1:0]    mem_rd_data,
    input  logic [VA_W-1:0]    paddr_ok,
    output logic [VA_W-1:0]    vaddr_q,
    output logic [VA_W-1:0]    base_q,
    output logic [FRAME_W-1:0] tframe_q,
    output logic               second_level,
    output logic               req_ready,
    output logic               mem_rd_valid,
    output logic               resp_valid,
    output logic [VA_W-1:0]    resp_paddr,
    output logic               resp_fault
);

    walk_state_t     state_q, state_d;
    logic [VA_W-1:0] paddr_q;
    logic            fault_q;
    logic            present;

    assign present = mem_rd_data[0];

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)    state_d = ST_READ_DIR;
            ST_READ_DIR: if (mem_rd_ready) state_d = present ? ST_READ_PTE : ST_DONE;
            ST_READ_PTE: if (mem_rd_ready) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q  <= '0;
            base_q   <= '0;
            tframe_q <= '0;
            paddr_q  <= '0;
            fault_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    base_q  <= dir_base;
                    paddr_q <= '0;
                    fault_q <= 1'b0;
                end
                ST_READ_DIR: if (mem_rd_ready) begin
                    tframe_q <= mem_rd_data[VA_W-1:OFF_W];
                    fault_q  <= !present;
                end
                ST_READ_PTE: if (mem_rd_ready) begin
                    fault_q <= !present;
                    paddr_q <= present ? paddr_ok : '0;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        resp_valid   = 1'b0;
        second_level = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_READ_DIR: mem_rd_valid = 1'b1;
            ST_READ_PTE: begin
                mem_rd_valid = 1'b1;
                second_level = 1'b1;
            end
            ST_DONE:     resp_valid = 1'b1;
            default: ;
        endcase
    end

    assign resp_paddr = paddr_q;
    assign resp_fault = fault_q;

    // R7: a pending read keeps its request
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid);

    // R9: response lasts one cycle and is followed by readiness
    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R8: readiness excludes any walk activity
    assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !resp_valid));

    // R5: absent directory entry faults at once, no table read
    assert_dir_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_DIR && mem_rd_ready && !present)
            |=> (resp_valid && resp_fault && resp_paddr == '0));

    // R6: absent table entry faults
    assert_pte_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (second_level && mem_rd_ready && !present) |=> (resp_valid && resp_fault));

endmodule

// File: rtl/pgwalk.sv
module pgwalk
    import pgwalk_pkg::*;
#(
    parameter int DIR_W = 8,
    parameter int PT_W  = 11,
    parameter int OFF_W = 13,
    localparam int VA_W    = DIR_W + PT_W + OFF_W,
    localparam int FRAME_W = VA_W - OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] dir_base,
    output logic            mem_rd_valid,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_ready,
    input  logic [VA_W-1:0] mem_rd_data,
    output logic            resp_valid,
    output logic [VA_W-1:0] resp_paddr,
    output logic            resp_fault
);

    logic [VA_W-1:0]    vaddr_q;
    logic [VA_W-1:0]    base_q;
    logic [FRAME_W-1:0] tframe_q;
    logic               second_level;
    logic [VA_W-1:0]    paddr_ok;

    pgwalk_addr #(.DIR_W(DIR_W), .PT_W(PT_W), .OFF_W(OFF_W)) u_addr (
        .vaddr        (vaddr_q),
        .base         (base_q),
        .tframe       (tframe_q),
        .second_level (second_level),
        .pte          (mem_rd_data),
        .rd_addr      (mem_rd_addr),
        .paddr_ok     (paddr_ok)
    );

    pgwalk_fsm #(.DIR_W(DIR_W), .PT_W(PT_W), .OFF_W(OFF_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .dir_base     (dir_base),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .paddr_ok     (paddr_ok),
        .vaddr_q      (vaddr_q),
        .base_q       (base_q),
        .tframe_q     (tframe_q),
        .second_level (second_level),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .resp_valid   (resp_valid),
        .resp_paddr   (resp_paddr),
        .resp_fault   (resp_fault)
    );

    // R7: address of a pending read is stable
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> $stable(mem_rd_addr));

endmodule

// File: tb/pgwalk_bench.sv
module pgwalk_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] dir_base = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    localparam logic [31:0] BASE = 32'h0040_0000;

    always #10 clk = ~clk;

    pgwalk u_pgwalk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .dir_base(dir_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    // memory model: directory region and hashed table entries
    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        logic [31:0] h;
        logic [7:0]  d;
        if (a[31:12] == BASE[31:12]) begin
            d = a[9:2];
            if (d % 5 != 0) return {19'h10000 + 19'(d) * 19'd2, 12'h0, 1'b1};
            return {19'h5A5A5, 13'h1FFE};
        end
        h = (a * 32'h9E37_79B1) ^ (a >> 7);
        return {h[31:1], (h[3:0] != 4'h0)};
    endfunction

    function automatic logic [31:0] exp_dir_addr(input logic [31:0] base, input logic [31:0] va);
        return base + {22'h0, va[31:24], 2'b00};
    endfunction

    function automatic logic [31:0] exp_pte_addr(input logic [31:0] de, input logic [31:0] va);
        return {de[31:13], va[23:13], 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one complete walk; hold keeps req_valid high throughout
    task automatic walk(input logic [31:0] va, input bit hold, input bit dirty_base);
        logic [31:0] de, pte, e_paddr;
        bit          e_fault;
        int          e_reads, nreads, lat, guard;
        bit          got;
        de = mem_fn(exp_dir_addr(BASE, va));
        pte = mem_fn(exp_pte_addr(de, va));
        e_fault = !de[0] || !pte[0];
        e_reads = de[0] ? 2 : 1;
        e_paddr = e_fault ? 32'h0 : {pte[31:13], va[12:0]};
        @(negedge clk);
        dir_base  = BASE;
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        if (dirty_base) dir_base = 32'hFFFF_0000;
        nreads = 0; lat = $urandom_range(0, 3); got = 0; guard = 0;
        while (!got && guard < 50) begin
            guard++;
            if (resp_valid) begin
                got = 1;
                check(nreads == e_reads, "R5 read count", nreads, e_reads);
                check(resp_fault == e_fault, e_de_tag(de), resp_fault, e_fault);
                check(resp_paddr == e_paddr, e_fault ? "R6 paddr" : "R4 paddr", resp_paddr, e_paddr);
            end else begin
                if (hold) check(!req_ready, "R8 ready busy", req_ready, 0);
                mem_rd_ready = 1'b0;
                if (mem_rd_valid) begin
                    if (nreads == 0)
                        check(mem_rd_addr == exp_dir_addr(BASE, va), "R2 dir addr", mem_rd_addr, exp_dir_addr(BASE, va));
                    else
                        check(mem_rd_addr == exp_pte_addr(de, va), "R3 pte addr", mem_rd_addr, exp_pte_addr(de, va));
                    if (lat == 0) begin
                        mem_rd_ready = 1'b1;
                        mem_rd_data  = mem_fn(mem_rd_addr);
                        nreads++;
                        lat = $urandom_range(0, 3);
                    end else begin
                        lat--;
                        mem_rd_data = $urandom;
                    end
                end
                @(negedge clk);
            end
        end
        check(got, "R9 response seen", 32'(got), 1);
        mem_rd_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(!resp_valid && req_ready, "R9 pulse then idle", {resp_valid, req_ready}, 2'b01);
        @(negedge clk);
        check(!mem_rd_valid && !resp_valid, "R8 no extra walk", {mem_rd_valid, resp_valid}, 0);
    endtask

    function automatic string e_de_tag(input logic [31:0] de);
        return de[0] ? "R6 fault flag" : "R5 fault flag";
    endfunction

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] va;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(req_ready && !resp_valid && !mem_rd_valid, "R1 reset outputs",
              {req_ready, resp_valid, mem_rd_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_rd_valid, "R1 after release",
              {req_ready, resp_valid, mem_rd_valid}, 3'b100);

        // R10: worked example, directory read at base + 0x340
        check(exp_dir_addr(BASE, 32'hD004000C) == BASE + 32'h340, "R10 split", exp_dir_addr(BASE, 32'hD004000C), BASE + 32'h340);
        walk(32'hD004000C, 0, 0);
        // R5: directory index 0x0A is absent
        walk(32'h0A12_3456, 0, 0);
        walk(32'h0000_1FFF, 1, 1);
        // R6: search a table index with an absent entry
        for (int i = 0; i < 2048; i++) begin
            va = {8'h21, 11'(i), 13'h1ABC};
            if (!mem_fn(exp_pte_addr(mem_fn(exp_dir_addr(BASE, va)), va))[0]) begin
                walk(va, 0, 0);
                break;
            end
        end
        walk(32'hFFFF_FFFF, 1, 0);
        for (int n = 0; n < 300; n++) begin
            va = $urandom;
            walk(va, n[0], n[1]);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule